// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host side of an ATA Multiword DMA data phase. Once it is started with a direction and a word count, it waits for the device to raise its DMA request. It then asserts the DMA acknowledge and issues a train of read or write strobes. Each strobe moves one 16-bit word across the shared device data bus. In the device-to-host direction the words go out on a valid/ready stream. In the host-to-device direction they are taken from a second valid/ready stream.

All strobe and acknowledge timing is counted in clock cycles. The counts are derived at elaboration from a clock-period parameter and the minimum times in nanoseconds, so the same code meets the bus limits at 48 MHz or at 250 MHz.

A burst ends in one of four ways:
- The device lowers its request, which is a device pause.
- The internal stream cannot take or supply the next word, which is a host pause.
- The host asks for a halt.
- The count runs out.

After a pause the engine releases the acknowledge and re-arms when conditions allow. It reports the end of the whole transfer with a one-cycle done or aborted pulse.

Top module: `mdma_host_engine`

## Requirements
Cycle counts below use T = CLK_PS/1000 ns and ceil() rounding. ASR = ceil(80/T). NEG = max(ceil(36/T), ceil(120/T) - ASR). SET = ceil(36/T). HLD = ceil(20/T).

- R1: During and after reset, dack_n, rd_stb_n and wr_stb_n are 1, and busy, done, aborted, rx_valid, tx_ready and bus_oe are 0.
- R2: A strobe is driven low only while dack_n is low. Only rd_stb_n pulses when rd_dir=1, and only wr_stb_n pulses when rd_dir=0. The two strobes are never low together. dack_n falls only after dreq has been seen high.
- R3: Every strobe stays low for exactly ASR cycles.
- R4: Between two strobes of one burst, the strobe stays high for exactly NEG cycles, so the word period is at least ceil(120/T) cycles.
- R5: dack_n is low for exactly SET cycles before the first strobe of each burst, including a burst that resumes after a pause.
- R6: After the last strobe of a burst rises, dack_n stays low for NEG + HLD cycles before it rises.
- R7: In a write, each word taken from the tx stream (tx_valid & tx_ready) appears on bus_out with bus_oe=1, in stream order. It is held unchanged from the cycle its strobe falls until the next word is taken or dack_n rises.
- R8: In a read, bus_in is sampled in the last cycle that rd_stb_n is low. The words are delivered on rx_data/rx_valid in bus order, each held until rx_ready.
- R9: A transfer performs exactly word_count strobes. done pulses for one cycle after dack_n has risen, and busy is 0 in that cycle.
- R10: If dreq is low when the negated phase after a word ends, the engine finishes that word and releases dack_n. It performs no further strobe until dreq returns high, then resumes with a new SET window.
- R11: If the rx slot is still full (read) or tx_valid is 0 (write) when the next word would start, the engine releases dack_n and waits. It resumes once the stream can move a word.
- R12: A halt seen while busy lets the current word complete. The engine then releases dack_n and pulses aborted instead of done.
- R13: A start with word_count = 0 pulses done one cycle later, with no strobe and no dack_n activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| rd_dir | input | 1 | 1 = device to host, 0 = host to device |
| word_count | input | CNT_W | Words to move |
| halt | input | 1 | Host request to end the transfer early |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: all words moved |
| aborted | output | 1 | Pulse: transfer ended by halt |
| tx_data | input | DATA_W | Word to write to the device |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Engine takes tx_data this cycle |
| rx_data | output | DATA_W | Word read from the device |
| rx_valid | output | 1 | rx_data is valid |
| rx_ready | input | 1 | Consumer accepts rx_data |
| dreq | input | 1 | Device DMA request (asynchronous) |
| dack_n | output | 1 | DMA acknowledge, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| bus_in | input | DATA_W | Data bus from the device |
| bus_out | output | DATA_W | Data bus to the device |
| bus_oe | output | 1 | Drive enable for bus_out |

## Verification
The properties assume the following about the inputs:
- dreq changes at arbitrary times, but only counts once it has passed the synchronizer.
- start arrives only while busy is 0.
- The tx stream keeps tx_data stable while tx_valid is high.

The bench models the device so that dreq drops only at a strobe's rising edge and is raised again only after dack_n has gone high. It changes start, halt and the stream controls only on falling clock edges.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_SETUP,
      ST_STROBE,
      ST_RECOV,
      ST_HOLD
   } mdma_state_e;

   // Smallest whole number of clock cycles covering t_ns
   function automatic int ns_to_cycles(input int t_ns, input int clk_ps);
      return (t_ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("mdma_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdma_timer.sv
module mdma_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   if (W < 1) begin : g_bad_w
      $error("mdma_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/mdma_rx_slot.sv
module mdma_rx_slot #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] cap_data,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   input  logic         out_ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else if (cap) begin
         out_data  <= cap_data;
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R8: a captured word is never overwritten before it is consumed
   p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> !out_valid || out_ready);
endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
   import mdma_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int CLK_PS      = 20833,
   parameter int T_CYC_NS    = 120,
   parameter int T_ASR_NS    = 80,
   parameter int T_NEG_NS    = 36,
   parameter int T_ACKSU_NS  = 36,
   parameter int T_ACKHD_NS  = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_dir,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              halt,
   output logic              busy,
   output logic              done,
   output logic              aborted,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic              dreq,
   output logic              dack_n,
   output logic              rd_stb_n,
   output logic              wr_stb_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   localparam int ASR_N = imax(1, ns_to_cycles(T_ASR_NS, CLK_PS));
   localparam int NEG_N = imax(1, imax(ns_to_cycles(T_NEG_NS, CLK_PS),
                                       ns_to_cycles(T_CYC_NS, CLK_PS) - ASR_N));
   localparam int SET_N = imax(1, ns_to_cycles(T_ACKSU_NS, CLK_PS));
   localparam int HLD_N = imax(1, ns_to_cycles(T_ACKHD_NS, CLK_PS));
   localparam int MAXN  = imax(imax(ASR_N, NEG_N), imax(SET_N, HLD_N));
   localparam int TMR_W = $clog2(MAXN + 1);
   localparam int AW    = $clog2(ASR_N + NEG_N + SET_N + HLD_N + 2) + 1;

   localparam logic [TMR_W-1:0] ASR_L = TMR_W'(ASR_N - 1);
   localparam logic [TMR_W-1:0] NEG_L = TMR_W'(NEG_N - 1);
   localparam logic [TMR_W-1:0] SET_L = TMR_W'(SET_N - 1);
   localparam logic [TMR_W-1:0] HLD_L = TMR_W'(HLD_N - 1);

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
      $error("mdma_host_engine: DATA_W out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("mdma_host_engine: CNT_W must be at least 1");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("mdma_host_engine: CLK_PS must be positive");
   end

   mdma_state_e st, nxt;
   logic              rd_q, halt_q;
   logic [CNT_W-1:0]  remain;
   logic [DATA_W-1:0] wd_q;
   logic              dreq_s, tmr_zero, ld;
   logic [TMR_W-1:0]  ldv;
   logic              take, cap, fin_done, fin_abort, flow_ok, last_word;

   mdma_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(dreq), .q(dreq_s)
   );

   mdma_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .zero(tmr_zero)
   );

   mdma_rx_slot #(.W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(bus_in),
      .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready)
   );

   assign flow_ok   = rd_q ? !rx_valid : tx_valid;
   assign last_word = (remain == '0);

   always_comb begin
      nxt       = st;
      ld        = 1'b0;
      ldv       = '0;
      take      = 1'b0;
      cap       = 1'b0;
      fin_done  = 1'b0;
      fin_abort = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               if (word_count == '0) fin_done = 1'b1;
               else                  nxt      = ST_ARM;
            end
         end
         ST_ARM: begin
            if (halt_q) begin
               nxt       = ST_IDLE;
               fin_abort = 1'b1;
            end else if (dreq_s && flow_ok) begin
               nxt = ST_SETUP;
               ld  = 1'b1;
               ldv = SET_L;
            end
         end
         ST_SETUP: begin
            if (tmr_zero) begin
               nxt  = ST_STROBE;
               ld   = 1'b1;
               ldv  = ASR_L;
               take = !rd_q;
            end
         end
         ST_STROBE: begin
            if (tmr_zero) begin
               nxt = ST_RECOV;
               ld  = 1'b1;
               ldv = NEG_L;
               cap = rd_q;
            end
         end
         ST_RECOV: begin
            if (tmr_zero) begin
               ld = 1'b1;
               if (last_word || halt_q || !dreq_s || !flow_ok) begin
                  nxt = ST_HOLD;
                  ldv = HLD_L;
               end else begin
                  nxt  = ST_STROBE;
                  ldv  = ASR_L;
                  take = !rd_q;
               end
            end
         end
         ST_HOLD: begin
            if (tmr_zero) begin
               if (last_word) begin
                  nxt      = ST_IDLE;
                  fin_done = 1'b1;
               end else if (halt_q) begin
                  nxt       = ST_IDLE;
                  fin_abort = 1'b1;
               end else begin
                  nxt = ST_ARM;
               end
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         rd_q    <= 1'b0;
         halt_q  <= 1'b0;
         remain  <= '0;
         wd_q    <= '0;
         done    <= 1'b0;
         aborted <= 1'b0;
      end else begin
         st      <= nxt;
         done    <= fin_done;
         aborted <= fin_abort;
         if (st == ST_IDLE) begin
            halt_q <= 1'b0;
            if (start) begin
               rd_q   <= rd_dir;
               remain <= word_count;
            end
         end else begin
            halt_q <= halt_q | halt;
         end
         if (st == ST_STROBE && tmr_zero) remain <= remain - 1'b1;
         if (take) wd_q <= tx_data;
      end
   end

   logic ack_on, stb_on;
   assign ack_on   = (st == ST_SETUP) || (st == ST_STROBE) ||
                     (st == ST_RECOV) || (st == ST_HOLD);
   assign stb_on   = (st == ST_STROBE);
   assign dack_n   = !ack_on;
   assign rd_stb_n = !(stb_on && rd_q);
   assign wr_stb_n = !(stb_on && !rd_q);
   assign bus_oe   = ack_on && !rd_q;
   assign bus_out  = wd_q;
   assign tx_ready = take;
   assign busy     = (st != ST_IDLE);

   // Observation counters that feed the timing properties only
   logic          strb_n, strb_lo_q, seen_q;
   logic [AW-1:0] lo_cnt, hi_cnt, ack_cnt, cyc_cnt;
   assign strb_n = rd_stb_n & wr_stb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_lo_q <= 1'b0;
         seen_q    <= 1'b0;
         lo_cnt    <= '0;
         hi_cnt    <= '0;
         ack_cnt   <= '0;
         cyc_cnt   <= '0;
      end else begin
         strb_lo_q <= !strb_n;
         lo_cnt    <= !strb_n ? ((&lo_cnt) ? lo_cnt : lo_cnt + 1'b1) : '0;
         hi_cnt    <= (!strb_n || dack_n) ? '0 : ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1);
         ack_cnt   <= dack_n ? '0 : ((&ack_cnt) ? ack_cnt : ack_cnt + 1'b1);
         cyc_cnt   <= (!strb_n && !strb_lo_q) ? AW'(1) :
                      ((&cyc_cnt) ? cyc_cnt : cyc_cnt + 1'b1);
         seen_q    <= dack_n ? 1'b0 : (seen_q | !strb_n);
      end
   end

   p_stb_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_n |-> !dack_n);
   p_one_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_stb_n && !wr_stb_n));
   p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) |-> lo_cnt == AW'(ASR_N));
   p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_n) && seen_q |-> hi_cnt == AW'(NEG_N) && cyc_cnt >= AW'(ASR_N + NEG_N));
   p_ack_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_n) && !seen_q |-> ack_cnt == AW'(SET_N));
   p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dack_n) |-> $past(hi_cnt) == AW'(NEG_N + HLD_N - 1));
   p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_n |=> $stable(bus_out) && bus_oe);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> dack_n && !busy && !aborted);
   p_abort_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> dack_n && !busy);
endmodule

// File: tb/mdma_host_engine_test.sv
`timescale 1ns/1ps
module mdma_host_engine_test;
   localparam int CLKP = 4000;
   // Expected cycle counts at 4 ns: ASR=20, NEG=max(9,30-20)=10, SET=9, HLD=5
   localparam int E_ASR = 20, E_NEG = 10, E_SET = 9, E_HOLD = 15;

   logic clk = 0, rst_n = 0;
   logic start = 0, rd_dir = 0, halt = 0;
   logic [15:0] word_count = 0;
   logic busy, done, aborted;
   logic [15:0] tx_data = 0;
   logic tx_valid = 0, tx_ready;
   logic [15:0] rx_data;
   logic rx_valid, rx_ready;
   logic dreq;
   logic dack_n, rd_stb_n, wr_stb_n;
   logic [15:0] bus_in = 0, bus_out;
   logic bus_oe;

   bit dev_req = 0, rx_en = 1;
   int drop_at = 0;
   assign dreq = dev_req;
   assign rx_ready = rx_en;

   always #2 clk = ~clk;

   mdma_host_engine #(.CLK_PS(CLKP)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_dir(rd_dir),
      .word_count(word_count), .halt(halt), .busy(busy), .done(done),
      .aborted(aborted), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .dreq(dreq), .dack_n(dack_n),
      .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   logic [15:0] dev_rd_q[$], exp_rx[$], tx_q[$], exp_wr[$];
   int nstrobe = 0, done_cnt = 0, abort_cnt = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Scoreboard driver tasks
   task automatic push_read(input logic [15:0] w);
      dev_rd_q.push_back(w);
      exp_rx.push_back(w);
   endtask
   task automatic push_write(input logic [15:0] w);
      tx_q.push_back(w);
      exp_wr.push_back(w);
   endtask

   // Device model: read data and strobe count
   always @(negedge rd_stb_n) if (rst_n)
      bus_in <= (dev_rd_q.size() > 0) ? dev_rd_q.pop_front() : 16'hDEAD;
   always @(negedge rd_stb_n or negedge wr_stb_n) if (rst_n) nstrobe++;
   always @(posedge rd_stb_n or posedge wr_stb_n)
      if (rst_n && drop_at != 0 && nstrobe == drop_at) dev_req = 0;
   // R7: device captures write word at strobe rise
   always @(posedge wr_stb_n) if (rst_n) begin
      logic [15:0] e;
      e = (exp_wr.size() > 0) ? exp_wr.pop_front() : 16'hBEEF;
      chk(bus_out == e && bus_oe, "R7", "write word", int'(bus_out), int'(e));
   end

   // tx stream source
   bit pend = 0;
   always @(negedge clk) begin
      if (pend) void'(tx_q.pop_front());
      tx_valid = tx_q.size() > 0;
      tx_data  = (tx_q.size() > 0) ? tx_q[0] : 16'h0;
      #1 pend = tx_valid && tx_ready;
   end

   // rx monitor (R8) and status monitors
   always @(negedge clk) if (rst_n) begin
      if (rx_valid && rx_ready) begin
         logic [15:0] e;
         e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hBEEF;
         chk(rx_data == e, "R8", "read word", int'(rx_data), int'(e));
      end
      if (done) done_cnt++;
      if (aborted) abort_cnt++;
   end

   // Timing monitor: 0 low width, 1 gap, 2 setup, 3 hold
   int mn[4], mx[4];
   int lo_run = 0, hi_run = 0, ack_run = 0;
   bit prev_lo = 0, prev_ackn = 1, seen = 0;
   function automatic void upd(input int i, input int v);
      if (v < mn[i]) mn[i] = v;
      if (v > mx[i]) mx[i] = v;
   endfunction
   always @(negedge clk) if (rst_n) begin
      bit lo;
      lo = !rd_stb_n || !wr_stb_n;
      if (lo && !prev_lo) begin
         if (seen) upd(1, hi_run); else upd(2, ack_run);
      end
      if (!lo && prev_lo) upd(0, lo_run);
      if (dack_n && !prev_ackn) upd(3, hi_run);
      if (lo) begin lo_run++; hi_run = 0; seen = 1; end
      else begin lo_run = 0; if (!dack_n) hi_run++; end
      if (dack_n) begin seen = 0; hi_run = 0; ack_run = 0; end
      else if (!seen) ack_run++;
      prev_lo = lo;
      prev_ackn = dack_n;
   end

   task automatic tclear();
      for (int i = 0; i < 4; i++) begin mn[i] = 1 << 30; mx[i] = -1; end
   endtask
   task automatic tcheck(input bit gaps);
      chk(mn[0] == E_ASR && mx[0] == E_ASR, "R3", "strobe low width", mx[0], E_ASR);
      if (gaps) chk(mn[1] == E_NEG && mx[1] == E_NEG, "R4", "strobe gap", mx[1], E_NEG);
      chk(mn[2] == E_SET && mx[2] == E_SET, "R5", "ack setup", mx[2], E_SET);
      chk(mn[3] == E_HOLD && mx[3] == E_HOLD, "R6", "ack hold", mx[3], E_HOLD);
   endtask

   task automatic kick(input bit dir, input int cnt);
      @(negedge clk);
      rd_dir = dir; word_count = 16'(cnt); start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_end(input int d0, input int a0);
      for (int i = 0; i < 5000; i++) begin
         if (done_cnt != d0 || abort_cnt != a0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int d0, a0, s0;
      tclear();
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(dack_n && rd_stb_n && wr_stb_n, "R1", "bus idle in reset", int'(dack_n), 1);
      chk(!busy && !done && !aborted && !rx_valid && !tx_ready && !bus_oe,
          "R1", "status idle in reset", int'(busy), 0);
      rst_n = 1;
      wait_cyc(3);
      chk(dack_n && rd_stb_n && wr_stb_n && !busy, "R1", "idle after reset", int'(dack_n), 1);

      // R2: no ack without request
      kick(1, 2);
      push_read(16'h1111); push_read(16'h2222);
      wait_cyc(40);
      chk(dack_n && nstrobe == 0, "R2", "no ack without dreq", nstrobe, 0);
      dev_req = 1;
      d0 = 0; wait_end(d0, 0);
      chk(nstrobe == 2 && done_cnt == 1, "R9", "2-word read strobes", nstrobe, 2);

      // Continuous read of 6 words (R8, R9, R3..R6)
      tclear(); s0 = nstrobe; d0 = done_cnt;
      for (int i = 0; i < 6; i++) push_read(16'(16'hA500 + i * 16'h0111));
      kick(1, 6); wait_end(d0, abort_cnt);
      chk(nstrobe - s0 == 6, "R9", "read strobe count", nstrobe - s0, 6);
      chk(done_cnt == d0 + 1 && !busy, "R9", "read done pulse", done_cnt - d0, 1);
      chk(exp_rx.size() == 0, "R8", "read words delivered", exp_rx.size(), 0);
      tcheck(1);

      // Write of 5 words (R7, R2)
      tclear(); s0 = nstrobe; d0 = done_cnt;
      for (int i = 0; i < 5; i++) push_write(16'(16'h3C00 ^ (i * 16'h1234)));
      kick(0, 5); wait_end(d0, abort_cnt);
      chk(nstrobe - s0 == 5, "R9", "write strobe count", nstrobe - s0, 5);
      chk(exp_wr.size() == 0, "R7", "write words consumed", exp_wr.size(), 0);
      chk(rd_stb_n && !bus_oe, "R2", "write leaves read strobe idle", int'(rd_stb_n), 1);
      tcheck(1);

      // R10: device pause after 3 of 8 words
      tclear(); s0 = nstrobe; d0 = done_cnt;
      for (int i = 0; i < 8; i++) push_read(16'(16'h0F00 + i));
      drop_at = s0 + 3;
      kick(1, 8);
      wait (dev_req == 0);
      wait_cyc(30);
      chk(nstrobe - s0 == 3 && dack_n, "R10", "paused after device drop", nstrobe - s0, 3);
      wait_cyc(40);
      chk(nstrobe - s0 == 3 && dack_n && busy, "R10", "stays paused", nstrobe - s0, 3);
      drop_at = 0; dev_req = 1;
      wait_end(d0, abort_cnt);
      chk(nstrobe - s0 == 8 && done_cnt == d0 + 1, "R10", "resumed to count", nstrobe - s0, 8);
      chk(exp_rx.size() == 0, "R8", "paused read order", exp_rx.size(), 0);
      tcheck(1);

      // R11: write stall, tx runs dry after 2 words
      tclear(); s0 = nstrobe; d0 = done_cnt;
      push_write(16'hC001); push_write(16'hC002);
      kick(0, 5);
      wait_cyc(150);
      chk(nstrobe - s0 == 2 && dack_n && busy, "R11", "write stall pause", nstrobe - s0, 2);
      push_write(16'hC003); push_write(16'hC004); push_write(16'hC005);
      wait_end(d0, abort_cnt);
      chk(nstrobe - s0 == 5 && exp_wr.size() == 0, "R11", "write resumes", nstrobe - s0, 5);
      tcheck(1);

      // R11: read stall, consumer not ready
      tclear(); s0 = nstrobe; d0 = done_cnt;
      rx_en = 0;
      for (int i = 0; i < 4; i++) push_read(16'(16'h7700 + i));
      kick(1, 4);
      wait_cyc(150);
      chk(nstrobe - s0 == 1 && dack_n && rx_valid, "R11", "read stall pause", nstrobe - s0, 1);
      rx_en = 1;
      wait_end(d0, abort_cnt);
      chk(nstrobe - s0 == 4 && exp_rx.size() == 0, "R11", "read resumes", nstrobe - s0, 4);

      // R12: host halt during 3rd word of 20
      s0 = nstrobe; d0 = done_cnt; a0 = abort_cnt;
      for (int i = 0; i < 3; i++) push_read(16'(16'h5A00 + i));
      kick(1, 20);
      wait (nstrobe - s0 == 3);
      @(negedge clk); halt = 1;
      wait_end(d0, a0);
      halt = 0;
      chk(abort_cnt == a0 + 1 && done_cnt == d0, "R12", "aborted not done", abort_cnt - a0, 1);
      chk(nstrobe - s0 == 3 && dack_n && !busy, "R12", "halt after current word", nstrobe - s0, 3);
      chk(exp_rx.size() == 0, "R12", "halted words delivered", exp_rx.size(), 0);

      // R13: zero count
      s0 = nstrobe; d0 = done_cnt;
      @(negedge clk);
      rd_dir = 0; word_count = 0; start = 1;
      @(negedge clk); start = 0;
      chk(done == 1 && dack_n, "R13", "zero-count done pulse", int'(done), 1);
      wait_cyc(20);
      chk(nstrobe == s0 && done_cnt == d0 + 1, "R13", "zero-count no strobe", nstrobe - s0, 0);

      wait_cyc(5);
      summary();
   end
endmodule